// File: doc/BRIEF.md
# Snoop Retry Responder

This block sits on the snooping side of a shared address bus. When another master starts a transfer, the block waits for the local cache to return a lookup verdict. If that verdict says the line is held modified, or that the snoop logic is too busy to service it, the block asserts the address-retry signal. It keeps the signal asserted through the cycle after the address acknowledge, drives it inactive for one cycle, and then releases the line.

When the retry was caused by a modified hit, the block uses the priority cycle that follows the qualified retry to request the bus. In that cycle no other master may request, so the copy-back runs before the retried master tries again. The block holds its request until it is granted, issues its own transfer start, and then signals the cache side with a one-cycle completion pulse. The lookup itself, the write-back data path and the arbiter are outside the block. The block handles one snoop at a time.

Top module: `snoop_retry_resp`

## Requirements
- R1: While reset is active and in the first cycle after it, retry_o, retry_oe_o, bus_req_o, cb_start_o and cb_done_o are all 0.
- R2: A valid lookup result with snp_hitm_i=1, seen in cycle k after a snooped transfer start in cycle 0, makes retry_o and retry_oe_o go to 1 in cycle k+1, so retry is never asserted before cycle 2. A result given in the transfer-start cycle itself is ignored.
- R3: A valid result with snp_busy_i=1 and snp_hitm_i=0 also asserts retry with the timing of R2.
- R4: A result is accepted only in cycles 1 to LAST-1 after the transfer start, where LAST is 2 when FAST_RATIO=0 and 3 when FAST_RATIO=1. A later result, or a valid result with both flags at 0, produces no retry.
- R5: Once asserted, retry_o stays 1 in every cycle up to and including the cycle after the cycle in which addr_ack_i is 1.
- R6: In the cycle after that, retry_o is 0 with retry_oe_o at 1. In the following cycle retry_oe_o is 0.
- R7: In that same release cycle, bus_req_o is 1 if and only if the retry was caused by a modified hit. A retry caused only by busy never raises bus_req_o.
- R8: bus_req_o stays 1 until bus_grant_i is sampled at 1 while it is asserted. cb_start_o is 1 for exactly the next cycle with bus_req_o still 1, and bus_req_o is 0 in the cycle after that.
- R9: cb_done_o is 1 for exactly one cycle, the cycle after cb_start_o.
- R10: If addr_ack_i is 1 before the lookup result arrives, or in the same cycle, the snoop is abandoned and no retry is asserted.
- R11: Transfer starts that arrive while a snoop is being handled, and bus_grant_i while no request is pending, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start_i | input | 1 | Transfer start from another master |
| addr_ack_i | input | 1 | Address acknowledge, one cycle wide |
| snp_valid_i | input | 1 | Lookup result valid |
| snp_hitm_i | input | 1 | Lookup hit a modified line |
| snp_busy_i | input | 1 | Snoop resources unable to service |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| retry_o | output | 1 | Address retry, active high |
| retry_oe_o | output | 1 | Drive enable for the retry line |
| bus_req_o | output | 1 | Bus request for the copy-back |
| cb_start_o | output | 1 | Transfer start of the copy-back |
| cb_done_o | output | 1 | Completion pulse to the cache side |

## Verification
The bench builds two instances from the same stimulus: one with FAST_RATIO=0, whose acceptance window is only cycle 1, and one with FAST_RATIO=1, whose window also covers cycle 2. A result that arrives in cycle 2 is therefore retried by one instance and dropped by the other. This checks both edges of the window in the same run. Acknowledge delays, grant delays and noise on the grant and transfer-start lines are drawn at random around these windows, so early aborts, an immediate grant in the priority cycle and long grant waits all occur.

// File: rtl/snoop_retry_pkg.sv
package snoop_retry_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_LOOK,
        RS_HOLD,
        RS_QUAL,
        RS_REL
    } rsp_state_e;

    typedef struct packed {
        rsp_state_e st;
        logic       hitm;
    } rsp_regs_t;

    typedef enum logic [1:0] {
        CB_IDLE,
        CB_WAIT,
        CB_ISSUE,
        CB_DONE
    } cb_state_e;

    typedef struct packed {
        cb_state_e st;
    } cb_regs_t;

endpackage

// File: rtl/snoop_win.sv
module snoop_win #(
    parameter int LAST_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic close_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(LAST_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_regs_t;

    win_regs_t win_d, win_q;
    logic      open_w;
    logic      last_w;

    assign open_w = (win_q.cnt != '0);
    assign last_w = (win_q.cnt == CNT_W'(LAST_CYC - 1));
    assign last_o = last_w;

    always_comb begin
        win_d = win_q;
        if (start_i) begin
            win_d.cnt = CNT_W'(1);
        end else if (open_w && (close_i || last_w)) begin
            win_d.cnt = '0;
        end else if (open_w) begin
            win_d.cnt = win_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/snoop_cb.sv
module snoop_cb
    import snoop_retry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_i,
    input  logic grant_i,
    output logic req_o,
    output logic issue_o,
    output logic done_o
);
    cb_regs_t cb_d, cb_q;

    always_comb begin
        cb_d = cb_q;
        case (cb_q.st)
            CB_IDLE: begin
                if (claim_i) begin
                    cb_d.st = grant_i ? CB_ISSUE : CB_WAIT;
                end
            end
            CB_WAIT: begin
                if (grant_i) begin
                    cb_d.st = CB_ISSUE;
                end
            end
            CB_ISSUE: cb_d.st = CB_DONE;
            CB_DONE:  cb_d.st = CB_IDLE;
            default:  cb_d.st = CB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_q.st <= CB_IDLE;
        end else begin
            cb_q <= cb_d;
        end
    end

    assign req_o   = (cb_q.st == CB_WAIT) || (cb_q.st == CB_ISSUE);
    assign issue_o = (cb_q.st == CB_ISSUE);
    assign done_o  = (cb_q.st == CB_DONE);
endmodule

// File: rtl/snoop_retry_resp.sv
module snoop_retry_resp
    import snoop_retry_pkg::*;
#(
    parameter bit FAST_RATIO = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start_i,
    input  logic addr_ack_i,
    input  logic snp_valid_i,
    input  logic snp_hitm_i,
    input  logic snp_busy_i,
    input  logic bus_grant_i,
    output logic retry_o,
    output logic retry_oe_o,
    output logic bus_req_o,
    output logic cb_start_o,
    output logic cb_done_o
);
    localparam int LAST_CYC = FAST_RATIO ? 3 : 2;

    rsp_regs_t rsp_d, rsp_q;
    logic      win_start;
    logic      win_close;
    logic      win_last;
    logic      must_retry;
    logic      claim;
    logic      cb_req;

    assign must_retry = snp_valid_i && (snp_hitm_i || snp_busy_i);
    assign win_start  = (rsp_q.st == RS_IDLE) && xfer_start_i;
    assign win_close  = (rsp_q.st == RS_LOOK) && (addr_ack_i || snp_valid_i);

    snoop_win #(
        .LAST_CYC(LAST_CYC)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(win_start),
        .close_i(win_close),
        .last_o (win_last)
    );

    always_comb begin
        rsp_d = rsp_q;
        case (rsp_q.st)
            RS_IDLE: begin
                if (xfer_start_i) begin
                    rsp_d.st = RS_LOOK;
                end
            end
            RS_LOOK: begin
                if (addr_ack_i) begin
                    rsp_d.st = RS_IDLE;
                end else if (must_retry) begin
                    rsp_d.st   = RS_HOLD;
                    rsp_d.hitm = snp_hitm_i;
                end else if (snp_valid_i || win_last) begin
                    rsp_d.st = RS_IDLE;
                end
            end
            RS_HOLD: begin
                if (addr_ack_i) begin
                    rsp_d.st = RS_QUAL;
                end
            end
            RS_QUAL: rsp_d.st = RS_REL;
            RS_REL:  rsp_d.st = RS_IDLE;
            default: rsp_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q.st   <= RS_IDLE;
            rsp_q.hitm <= 1'b0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign claim = (rsp_q.st == RS_REL) && rsp_q.hitm;

    snoop_cb u_cb (
        .clk    (clk),
        .rst_n  (rst_n),
        .claim_i(claim),
        .grant_i(bus_grant_i),
        .req_o  (cb_req),
        .issue_o(cb_start_o),
        .done_o (cb_done_o)
    );

    assign retry_o    = (rsp_q.st == RS_HOLD) || (rsp_q.st == RS_QUAL);
    assign retry_oe_o = retry_o || (rsp_q.st == RS_REL);
    assign bus_req_o  = claim || cb_req;
endmodule

// File: rtl/snoop_retry_chk.sv
module snoop_retry_chk (
    input logic clk,
    input logic rst_n,
    input logic addr_ack_i,
    input logic snp_valid_i,
    input logic snp_hitm_i,
    input logic snp_busy_i,
    input logic bus_grant_i,
    input logic retry_o,
    input logic retry_oe_o,
    input logic bus_req_o,
    input logic cb_start_o,
    input logic cb_done_o
);
    assert_retry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_o) |-> $past(snp_valid_i && (snp_hitm_i || snp_busy_i)));

    assert_retry_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> retry_oe_o);

    assert_hold_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_o) |-> $past(addr_ack_i, 2));

    assert_release_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_o) |-> retry_oe_o);

    assert_oe_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_oe_o) |-> $past(!retry_o));

    assert_req_in_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> $fell(retry_o));

    assert_start_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cb_start_o) |-> $past(bus_grant_i && bus_req_o));

    assert_start_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cb_start_o |-> bus_req_o);

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> $past(cb_start_o));

    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cb_done_o |-> $past(cb_start_o));
endmodule

bind snoop_retry_resp snoop_retry_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_ack_i (addr_ack_i),
    .snp_valid_i(snp_valid_i),
    .snp_hitm_i (snp_hitm_i),
    .snp_busy_i (snp_busy_i),
    .bus_grant_i(bus_grant_i),
    .retry_o    (retry_o),
    .retry_oe_o (retry_oe_o),
    .bus_req_o  (bus_req_o),
    .cb_start_o (cb_start_o),
    .cb_done_o  (cb_done_o)
);

// File: tb/tb_snoop_retry_resp.sv
`timescale 1ns/1ps
module tb_snoop_retry_resp;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start_i = 1'b0;
    logic addr_ack_i = 1'b0;
    logic snp_valid_i = 1'b0;
    logic snp_hitm_i = 1'b0;
    logic snp_busy_i = 1'b0;
    logic bus_grant_i = 1'b0;
    logic [4:0] out_n;
    logic [4:0] out_f;

    int compared = 0;
    int mismatched = 0;

    int k, a, g;
    bit hm, bz, n0, nts;

    always #2 clk = ~clk;

    snoop_retry_resp #(.FAST_RATIO(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i), .addr_ack_i(addr_ack_i),
        .snp_valid_i(snp_valid_i), .snp_hitm_i(snp_hitm_i), .snp_busy_i(snp_busy_i),
        .bus_grant_i(bus_grant_i), .retry_o(out_n[4]), .retry_oe_o(out_n[3]),
        .bus_req_o(out_n[2]), .cb_start_o(out_n[1]), .cb_done_o(out_n[0]));

    snoop_retry_resp #(.FAST_RATIO(1'b1)) dut_fast (
        .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i), .addr_ack_i(addr_ack_i),
        .snp_valid_i(snp_valid_i), .snp_hitm_i(snp_hitm_i), .snp_busy_i(snp_busy_i),
        .bus_grant_i(bus_grant_i), .retry_o(out_f[4]), .retry_oe_o(out_f[3]),
        .bus_req_o(out_f[2]), .cb_start_o(out_f[1]), .cb_done_o(out_f[0]));

    function automatic bit retries(int last);
        return (k <= last - 1) && (hm || bz) && (a > k);
    endfunction

    // expected {retry, oe, req, start, done} in cycle c of a scenario
    function automatic logic [4:0] exp_vec(int c, int last);
        bit r = retries(last);
        bit h = r && hm;
        logic [4:0] v;
        v[4] = r && (c >= k + 1) && (c <= a + 1);
        v[3] = r && (c >= k + 1) && (c <= a + 2);
        v[2] = h && (c >= a + 2) && (c <= g + 1);
        v[1] = h && (c == g + 1);
        v[0] = h && (c == g + 2);
        return v;
    endfunction

    function automatic string retry_tag(int last);
        if (retries(last)) return hm ? "R2" : "R3";
        if (a <= k && k <= last - 1) return "R10";
        return "R4";
    endfunction

    task automatic check_bit(logic act, logic exp, string tag, string what, int c);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b (k=%0d a=%0d g=%0d hm=%0b bz=%0b)",
                     tag, what, c, act, exp, k, a, g, hm, bz);
        end
    endtask

    task automatic check_dut(logic [4:0] act, int last, int c, string nm);
        logic [4:0] e = exp_vec(c, last);
        string rt = retry_tag(last);
        bit h = retries(last) && hm;
        check_bit(act[4], e[4], (c > a + 1 && retries(last)) ? "R5" : rt, {nm, " retry"}, c);
        check_bit(act[3], e[3], "R6", {nm, " retry_oe"}, c);
        check_bit(act[2], e[2], h ? "R8" : (retries(last) ? "R7" : "R11"), {nm, " bus_req"}, c);
        check_bit(act[1], e[1], h ? "R8" : "R11", {nm, " cb_start"}, c);
        check_bit(act[0], e[0], "R9", {nm, " cb_done"}, c);
    endtask

    task automatic run_scenario();
        int last_c = (g + 4 > k + 6) ? g + 4 : k + 6;
        for (int c = 0; c <= last_c; c++) begin
            @(negedge clk);
            check_dut(out_n, 2, c, "norm");
            check_dut(out_f, 3, c, "fast");
            xfer_start_i = (c == 0) || (nts && c == k + 1);
            addr_ack_i   = (c == a);
            snp_valid_i  = (c == k) || (n0 && c == 0);
            snp_hitm_i   = (c == k) ? hm : (c == 0);
            snp_busy_i   = (c == k) ? bz : 1'b0;
            bus_grant_i  = (c == g) || ((c < a + 2) && ($urandom % 3 == 0));
        end
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        print_summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        for (int i = 0; i < 5; i++) begin
            check_bit(out_n[i], 1'b0, "R1", "norm reset", 0);
            check_bit(out_f[i], 1'b0, "R1", "fast reset", 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            check_bit(out_n[i], 1'b0, "R1", "norm after reset", 0);
            check_bit(out_f[i], 1'b0, "R1", "fast after reset", 0);
        end
        for (int s = 0; s < 500; s++) begin
            n0 = 1'b0; nts = 1'b0;
            case (s)
                0: begin k = 1; hm = 1; bz = 0; a = 2; g = 4; n0 = 1; end  // R2 earliest, immediate grant
                1: begin k = 1; hm = 0; bz = 1; a = 3; g = 5; end          // R3, R7 busy only
                2: begin k = 2; hm = 1; bz = 0; a = 4; g = 9; end          // R4 window edge
                3: begin k = 1; hm = 1; bz = 0; a = 1; g = 3; end          // R10 ack with result
                4: begin k = 1; hm = 0; bz = 0; a = 3; g = 5; end          // R4 clean result
                5: begin k = 1; hm = 1; bz = 1; a = 5; g = 11; nts = 1; end // R11, R8 long wait
                default: begin
                    k  = 1 + int'($urandom % 4);
                    hm = bit'($urandom % 2);
                    bz = bit'($urandom % 2);
                    if ($urandom % 5 == 0) a = 1 + int'($urandom % k);
                    else a = k + 1 + int'($urandom % 4);
                    g   = a + 2 + int'($urandom % 5);
                    n0  = bit'($urandom % 2);
                    nts = bit'($urandom % 2);
                end
            endcase
            run_scenario();
        end
        print_summary();
        $finish;
    end
endmodule